// File: doc/BRIEF.md
# Pipelined Serial ADC Channel Scanner

This block is the master side of a four-wire serial link to an external 10-bit converter with nine analog inputs. Once enabled it runs on its own: every 16-bit full-duplex frame carries out the number of the channel to convert next and carries in the conversion of the channel named one frame earlier. Between frames the converter needs time to finish. The scanner either supplies a fixed train of 44 converter-clock pulses or waits for the converter's end-of-conversion line. In the second case a timeout protects against a converter that never answers.

The latest result of each channel is held in a nine-entry result file, which is exposed as one flat vector with a valid flag per channel. The frame can go out as one 16-clock burst or as two 8-clock bytes with an idle gap between them. Chip select stays low across the gap. The serial clock is the system clock divided by a programmable amount.

The controller is a five-state machine:
- IDLE resets the channel pointer and goes to START while `enable` is high.
- START waits for the next divider tick and then lowers chip select. It returns to IDLE if `enable` drops.
- SHIFT runs the 32 serial half-periods. After bit 7 in split mode it moves to GAP. After bit 15 it raises chip select and moves to CONV.
- GAP holds the clock low for a fixed number of ticks and then returns to SHIFT.
- CONV waits for the conversion. It goes to START when the pulse count is done, when end-of-conversion is seen, or when the timeout expires (after restarting the sequence). It goes to IDLE if `enable` has dropped.

Top module: `adc_scan`

## Requirements
- R1: While reset is asserted, `cs_n` is 1, `sck`, `conv_clk`, `eoc_irq` and `timeout_err` are 0, and all results and valid flags are 0.
- R2: In each outgoing 16-bit frame, sent MSB first, bits 15..12 carry the channel number and bits 11..0 are 0.
- R3: The channels sent follow 0,1,…,8 and then 0 again. Each start from idle, and each timeout restart, begins again at channel 0.
- R4: The 10-bit result is bits 15..6 of the received frame. It is stored for the channel sent in the preceding frame. The first frame after each start or restart stores nothing.
- R5: Channel c's result sits at `results[10c+9:10c]`. Its `valid[c]` bit is set on the first store and is cleared only by reset. Stores take effect on the clock edge that raises `cs_n`.
- R6: The serial clock uses SPI mode 0. `sck` is low whenever `cs_n` is high, and each frame has exactly 16 rising edges. `miso` is sampled on the rising edge and `mosi` changes on the falling edge. Within a byte, `sck` stays low for `clk_div+1` system clocks between a falling and the next rising edge.
- R7: With `split_mode`=1, `sck` stays low for 4×(`clk_div`+1) clocks between the 8th and 9th bit, and `cs_n` stays low throughout.
- R8: With `eoc_mode`=0, exactly 44 `conv_clk` pulses occur between one frame and the next, and `conv_clk` is low during frames.
- R9: With `eoc_mode`=1, no frame starts before `eoc` is seen high. Each conversion raises a single one-cycle `eoc_irq` pulse, and `conv_clk` stays low.
- R10: With `eoc_mode`=1, if `eoc` stays low for TIMEOUT_CYC clocks after a frame, `timeout_err` is set and stays set until reset. The next frame then follows within `clk_div`+1 clocks and sends channel 0.
- R11: When `enable` drops, any frame in progress completes, and no new frame starts while `enable` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the scan |
| eoc_mode | input | 1 | 1: pace by end-of-conversion, 0: pace by counted pulses |
| split_mode | input | 1 | 1: send frame as two bytes with a gap |
| clk_div | input | DIV_W | Serial half-period minus one, in system clocks |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| conv_clk | output | 1 | Converter clock in counted mode |
| eoc | input | 1 | End-of-conversion from converter |
| eoc_irq | output | 1 | One-cycle pulse on end-of-conversion |
| timeout_err | output | 1 | Sticky end-of-conversion timeout flag |
| results | output | NUM_CH*RES_W | Latest result per channel |
| valid | output | NUM_CH | Result-present flag per channel |

## Verification
Results and valid flags are due on the same clock edge that raises `cs_n`. The bench's converter model therefore updates its expected file in the sample where it first sees `cs_n` high, and it compares the whole file every cycle. Serial timing is measured in system clocks between sampled `sck` edges: `clk_div`+1 within a byte, and four times that across the split gap. Conversion pacing is counted in the interval where `cs_n` is high. That interval must hold 44 `conv_clk` pulses, or one `eoc_irq` after `eoc`. After a missing end-of-conversion it must be TIMEOUT_CYC+1 to TIMEOUT_CYC+`clk_div`+1 clocks long.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_GAP,
        ST_CONV
    } scan_state_e;

endpackage

// File: rtl/adc_scan_tick.sv
`timescale 1ns/1ps
module adc_scan_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // one tick every div+1 clocks, free running
    assign tick = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_scan_results.sv
`timescale 1ns/1ps
module adc_scan_results #(
    parameter int NUM_CH = 9,
    parameter int ADDR_W = 4,
    parameter int RES_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_ch,
    input  logic [RES_W-1:0]        wr_data,
    output logic [NUM_CH*RES_W-1:0] results,
    output logic [NUM_CH-1:0]       valid
);

    logic [RES_W-1:0]  mem_q [NUM_CH];
    logic [NUM_CH-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                mem_q[i] <= '0;
            end
            vld_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_en && (wr_ch == ADDR_W'(i))) begin
                    mem_q[i] <= wr_data;
                    vld_q[i] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        assign results[g*RES_W +: RES_W] = mem_q[g];
    end
    assign valid = vld_q;

    // valid flags only ever gain bits outside reset
    assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~vld_q) & $past(vld_q)) == '0);

    // writes come only for channels that exist
    assert_wr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ch < ADDR_W'(NUM_CH)));

endmodule

// File: rtl/adc_scan.sv
`timescale 1ns/1ps
module adc_scan
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH      = 9,
    parameter int ADDR_W      = 4,
    parameter int FRAME_W     = 16,
    parameter int RES_W       = 10,
    parameter int DIV_W       = 8,
    parameter int CONV_CYCLES = 44,
    parameter int GAP_TICKS   = 3,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    eoc_mode,
    input  logic                    split_mode,
    input  logic [DIV_W-1:0]        clk_div,
    output logic                    sck,
    output logic                    cs_n,
    output logic                    mosi,
    input  logic                    miso,
    output logic                    conv_clk,
    input  logic                    eoc,
    output logic                    eoc_irq,
    output logic                    timeout_err,
    output logic [NUM_CH*RES_W-1:0] results,
    output logic [NUM_CH-1:0]       valid
);

    localparam int BIT_W  = $clog2(FRAME_W);
    localparam int HALF   = FRAME_W / 2;
    localparam int PAD_W  = FRAME_W - ADDR_W;
    localparam int CONV_W = $clog2(CONV_CYCLES + 1);
    localparam int TO_W   = $clog2(TIMEOUT_CYC);
    localparam int GAP_W  = $clog2(GAP_TICKS + 1);

    scan_state_e state_q, state_nx;

    logic               tick;
    logic               sck_q, cs_n_q, conv_q, irq_q, err_q, eoc_q;
    logic [FRAME_W-1:0] tx_q, rx_q;
    logic [BIT_W-1:0]   bit_cnt;
    logic [GAP_W-1:0]   gap_cnt;
    logic [CONV_W-1:0]  conv_cnt;
    logic [TO_W-1:0]    to_cnt;
    logic [ADDR_W-1:0]  ch_ptr, cur_ch, last_ch;
    logic               have_prev;
    logic               last_bit, mid_bit, gap_done, conv_done, to_expire;
    logic               wr_en;

    adc_scan_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (clk_div),
        .tick  (tick)
    );

    assign last_bit  = (bit_cnt == BIT_W'(FRAME_W - 1));
    assign mid_bit   = (bit_cnt == BIT_W'(HALF - 1));
    assign gap_done  = (gap_cnt == GAP_W'(GAP_TICKS - 1));
    assign conv_done = (conv_cnt == CONV_W'(CONV_CYCLES));
    assign to_expire = (to_cnt == TO_W'(TIMEOUT_CYC - 1));

    // store on the falling tick that ends the frame
    assign wr_en = (state_q == ST_SHIFT) && tick && sck_q && last_bit && have_prev;

    adc_scan_results #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .RES_W  (RES_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (last_ch),
        .wr_data (rx_q[FRAME_W-1 -: RES_W]),
        .results (results),
        .valid   (valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_nx = ST_START;
            end
            ST_START: begin
                if (!enable)   state_nx = ST_IDLE;
                else if (tick) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick && sck_q) begin
                    if (last_bit)                   state_nx = ST_CONV;
                    else if (split_mode && mid_bit) state_nx = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tick && gap_done) state_nx = ST_SHIFT;
            end
            ST_CONV: begin
                if (!enable) begin
                    state_nx = ST_IDLE;
                end else if (eoc_mode) begin
                    if (eoc_q || to_expire) state_nx = ST_START;
                end else if (tick && conv_q && conv_done) begin
                    state_nx = ST_START;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_q <= 1'b0;
        end else begin
            eoc_q <= eoc;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            cs_n_q    <= 1'b1;
            tx_q      <= '0;
            rx_q      <= '0;
            bit_cnt   <= '0;
            gap_cnt   <= '0;
            conv_q    <= 1'b0;
            conv_cnt  <= '0;
            to_cnt    <= '0;
            ch_ptr    <= '0;
            cur_ch    <= '0;
            last_ch   <= '0;
            have_prev <= 1'b0;
            irq_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cs_n_q    <= 1'b1;
                    sck_q     <= 1'b0;
                    conv_q    <= 1'b0;
                    ch_ptr    <= '0;
                    have_prev <= 1'b0;
                end
                ST_START: begin
                    if (enable && tick) begin
                        cs_n_q  <= 1'b0;
                        sck_q   <= 1'b0;
                        tx_q    <= {ch_ptr, {PAD_W{1'b0}}};
                        cur_ch  <= ch_ptr;
                        ch_ptr  <= (ch_ptr == ADDR_W'(NUM_CH - 1)) ? '0 : ch_ptr + 1'b1;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                            rx_q  <= {rx_q[FRAME_W-2:0], miso};
                        end else begin
                            sck_q   <= 1'b0;
                            tx_q    <= {tx_q[FRAME_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                            gap_cnt <= '0;
                            if (last_bit) begin
                                cs_n_q    <= 1'b1;
                                last_ch   <= cur_ch;
                                have_prev <= 1'b1;
                                conv_cnt  <= '0;
                                conv_q    <= 1'b0;
                                to_cnt    <= '0;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) gap_cnt <= gap_cnt + 1'b1;
                end
                ST_CONV: begin
                    if (enable) begin
                        if (eoc_mode) begin
                            if (eoc_q) begin
                                irq_q <= 1'b1;
                            end else if (to_expire) begin
                                err_q     <= 1'b1;
                                ch_ptr    <= '0;
                                have_prev <= 1'b0;
                            end else begin
                                to_cnt <= to_cnt + 1'b1;
                            end
                        end else if (tick) begin
                            if (!conv_q) begin
                                conv_q   <= 1'b1;
                                conv_cnt <= conv_cnt + 1'b1;
                            end else begin
                                conv_q <= 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sck         = sck_q;
    assign cs_n        = cs_n_q;
    assign mosi        = tx_q[FRAME_W-1];
    assign conv_clk    = conv_q;
    assign eoc_irq     = irq_q;
    assign timeout_err = err_q;

    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_conv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !conv_clk);

    assert_conv_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_cnt <= CONV_W'(CONV_CYCLES));

    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(timeout_err) |-> timeout_err);

endmodule

// File: tb/adc_scan_tb.sv
`timescale 1ns/1ps
module adc_scan_tb;

    localparam int NCH   = 9;
    localparam int RW    = 10;
    localparam int TOUT  = 600;
    localparam int GAPT  = 3;
    localparam int NCONV = 44;
    localparam int WD    = 150000;

    logic clk = 1'b0;
    logic rst_n, enable, eoc_mode, split_mode;
    logic [7:0] clk_div;
    logic sck, cs_n, mosi, miso, conv_clk, eoc, eoc_irq, timeout_err;
    logic [NCH*RW-1:0] results;
    logic [NCH-1:0]    valid;

    always #2.5 clk = ~clk;

    adc_scan #(.TIMEOUT_CYC(TOUT)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .eoc_mode    (eoc_mode),
        .split_mode  (split_mode),
        .clk_div     (clk_div),
        .sck         (sck),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .miso        (miso),
        .conv_clk    (conv_clk),
        .eoc         (eoc),
        .eoc_irq     (eoc_irq),
        .timeout_err (timeout_err),
        .results     (results),
        .valid       (valid)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int frames = 0;

    // converter and reference model state
    logic [RW-1:0]  m_res [NCH];
    logic [NCH-1:0] m_vld;
    int   exp_next, last_addr, nconv, bitn, rises, lowcnt, convcnt, irqcnt, hicnt;
    int   eoc_delay = 30;
    bit   have_prev, seen_fall, any_frame, suppress;
    bit   prev_cs, prev_sck, prev_conv;
    logic [15:0] txf, rxm;
    logic [RW-1:0] pend_val;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] adc_val(input int ch, input int n);
        return RW'((ch * 97 + n * 13 + 5) % 1024);
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) m_res[i] = '0;
            m_vld     = '0;
            exp_next  = 0;
            have_prev = 0;
            any_frame = 0;
            last_addr = 0;
            nconv     = 0;
            hicnt     = 0;
            convcnt   = 0;
            irqcnt    = 0;
            miso      = 1'b0;
            eoc       = 1'b0;
            prev_cs   = 1'b1;
            prev_sck  = 1'b0;
            prev_conv = 1'b0;
        end else begin
            // frame start
            if (prev_cs && !cs_n) begin
                if (eoc_mode && suppress) begin
                    if (any_frame)
                        chk(hicnt >= TOUT + 1 && hicnt <= TOUT + int'(clk_div) + 1,
                            "R10 timeout interval", hicnt, TOUT + 1);
                    exp_next  = 0;
                    have_prev = 0;
                end else if (have_prev) begin
                    if (eoc_mode) begin
                        chk(irqcnt == 1, "R9 one irq per conversion", irqcnt, 1);
                        chk(convcnt == 0, "R9 no converter clock", convcnt, 0);
                        chk(hicnt > eoc_delay, "R9 frame waits for eoc", hicnt, eoc_delay + 1);
                    end else begin
                        chk(convcnt == NCONV, "R8 converter pulses", convcnt, NCONV);
                    end
                end
                eoc     = 1'b0;
                irqcnt  = 0;
                convcnt = 0;
                txf = have_prev ? {adc_val(last_addr, nconv), 6'b0} : 16'hFFFF;
                pend_val = txf[15:6];
                nconv++;
                miso      = txf[15];
                bitn      = 0;
                rises     = 0;
                rxm       = '0;
                seen_fall = 0;
                lowcnt    = 0;
            end
            // serial edges
            if (!cs_n) begin
                if (!prev_sck && sck) begin
                    rxm = {rxm[14:0], mosi};
                    if (seen_fall) begin
                        if (split_mode && rises == 8)
                            chk(lowcnt == (GAPT + 1) * (int'(clk_div) + 1), "R7 byte gap",
                                lowcnt, (GAPT + 1) * (int'(clk_div) + 1));
                        else
                            chk(lowcnt == int'(clk_div) + 1, "R6 half period",
                                lowcnt, int'(clk_div) + 1);
                    end
                    rises++;
                end
                if (prev_sck && !sck) begin
                    bitn++;
                    if (bitn < 16) miso = txf[15 - bitn];
                    seen_fall = 1;
                    lowcnt    = 1;
                end else if (!sck && seen_fall) begin
                    lowcnt++;
                end
            end
            // frame end
            if (!prev_cs && cs_n) begin
                chk(rises == 16, "R6 rising edges per frame", rises, 16);
                chk(rxm[11:0] == 12'h000, "R2 padding bits zero", int'(rxm[11:0]), 0);
                chk(int'(rxm[15:12]) == exp_next, "R3 channel order", int'(rxm[15:12]), exp_next);
                if (have_prev) begin
                    m_res[last_addr] = pend_val;
                    m_vld[last_addr] = 1'b1;
                end
                last_addr = exp_next;
                exp_next  = (exp_next + 1) % NCH;
                have_prev = 1;
                any_frame = 1;
                frames++;
                hicnt = 0;
            end
            if (cs_n) begin
                hicnt++;
                if (!prev_conv && conv_clk) convcnt++;
                if (eoc_mode && !suppress && any_frame && hicnt == eoc_delay) eoc = 1'b1;
                if (!enable) begin
                    exp_next  = 0;
                    have_prev = 0;
                end
            end
            if (eoc_irq) irqcnt++;
            // every-cycle comparison of the result file (R4, R5)
            chk(valid == m_vld, "R5 valid flags", int'(valid), int'(m_vld));
            begin
                int bad;
                bad = -1;
                for (int c = 0; c < NCH; c++)
                    if (bad < 0 && results[c*RW +: RW] != m_res[c]) bad = c;
                if (bad < 0) chk(1'b1, "R4 result", 0, 0);
                else chk(1'b0, "R4 result", int'(results[bad*RW +: RW]), int'(m_res[bad]));
            end
            prev_cs   = cs_n;
            prev_sck  = sck;
            prev_conv = conv_clk;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) begin
            @(negedge clk);
            if (cyc > WD) begin
                checks++;
                errors++;
                $display("FAIL watchdog frames=%0d expected=%0d", frames, target);
                finish_run();
            end
        end
        #1;
    endtask

    task automatic check_disabled;
        int f0;
        enable = 1'b0;
        step(100);
        f0 = frames;
        step(600);
        chk(frames == f0, "R11 no frame while disabled", frames, f0);
        chk(cs_n == 1'b1, "R11 chip select idle", int'(cs_n), 1);
    endtask

    initial begin
        rst_n      = 1'b0;
        enable     = 1'b0;
        eoc_mode   = 1'b0;
        split_mode = 1'b0;
        clk_div    = 8'd2;
        suppress   = 0;
        step(5);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sck == 1'b0, "R1 sck in reset", int'(sck), 0);
        chk(conv_clk == 1'b0, "R1 conv_clk in reset", int'(conv_clk), 0);
        chk(eoc_irq == 1'b0 && timeout_err == 1'b0, "R1 flags in reset",
            int'({eoc_irq, timeout_err}), 0);
        chk(valid == '0 && results == '0, "R1 result file in reset", int'(valid), 0);
        rst_n = 1'b1;
        step(3);

        // counted pacing, single burst, two full wraps (R2 R3 R4 R6 R8)
        enable = 1'b1;
        wait_frames(22);
        check_disabled();

        // split frames with faster clock (R7)
        split_mode = 1'b1;
        clk_div    = 8'd1;
        enable     = 1'b1;
        wait_frames(12);
        check_disabled();

        // end-of-conversion pacing (R9)
        split_mode = 1'b0;
        eoc_mode   = 1'b1;
        clk_div    = 8'd0;
        enable     = 1'b1;
        wait_frames(12);
        chk(timeout_err == 1'b0, "R10 no timeout when eoc answers", int'(timeout_err), 0);
        check_disabled();

        // missing end-of-conversion (R10)
        rst_n    = 1'b0;
        suppress = 1;
        step(4);
        rst_n = 1'b1;
        step(2);
        enable = 1'b1;
        wait_frames(4);
        chk(timeout_err == 1'b1, "R10 timeout flag set", int'(timeout_err), 1);
        chk(valid == '0, "R10 restart stores nothing", int'(valid), 0);
        step(50);
        chk(timeout_err == 1'b1, "R10 timeout flag sticky", int'(timeout_err), 1);
        enable = 1'b0;
        step(20);
        finish_run();
    end

endmodule